// File: doc/BRIEF.md
# Multi-Lane SPI Shift Engine

This block is the master side of a serial link that moves one data word per transfer over one, two or four data lines. The transmit word and the received word move in the same SCLK cycles. The word length can be set from 4 to 32 bits in steps of four bits. The bit order can be most significant bit first or least significant bit first. The SCLK is made from the system clock through a programmable divider. One of four active-low chip selects frames the transfer.

The host sets up the word, the length code, the lane code, the order flag, the slave index and the divider value, then pulses `start` for one clock. The engine then runs the whole transfer by itself. After the chip select goes high again, `done` pulses for one clock and `rx_word` holds the received word. Setup inputs that change while the engine is busy have no effect.

Top module: `mlspi_engine`

## Requirements
- R1: `len_code` n (3 bits) selects a transfer of 4*(n+1) bits. Only the lowest 4*(n+1) bits of `tx_word` are sent, and `rx_word` comes back zero-extended above that length.
- R2: With `lsb_first`=0 the first group on the wire holds the most significant bits of the selected length, and later groups move toward bit 0. With `lsb_first`=1 groups are taken from bit 0 upward. In both orders the higher-numbered bit of a group sits on the higher-numbered lane.
- R3: `lane_mode` 0 uses line 0 only (`sd_oe`=0001). `lane_mode` 1 uses lines 1:0 (`sd_oe`=0011), with the more significant bit on line 1. `lane_mode` 2 or 3 uses lines 3:0 (`sd_oe`=1111), with the most significant bit on line 3. Input lines outside the active set are ignored.
- R4: The word is received over the same SCLK cycles as the transmit word and is assembled with the same group order and lane mapping as R2 and R3.
- R5: SCLK is low whenever no chip select is active. Each SCLK half-period lasts `clk_div`+1 system clocks. Outputs change on falling edges and inputs are sampled on rising edges. A transfer holds the chip select low for exactly 2*N*(`clk_div`+1) clocks, where N = bits / lanes.
- R6: During a transfer only `cs_n[cs_sel]` is low, and it stays low for the whole transfer. All chip selects are high otherwise.
- R7: While `busy` is high, `start` and every setup input are ignored. The running transfer is unchanged and no second transfer follows it.
- R8: `done` is high for exactly one clock, the first clock after the chip select returns high. `rx_word` changes only at that point and then holds until the next transfer completes.
- R9: After reset all chip selects are high, SCLK is low, `sd_oe` is 0, `busy` and `done` are 0, and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock request to begin a transfer |
| tx_word | input | 32 | Word to transmit |
| len_code | input | 3 | Length code, 4*(n+1) bits |
| lane_mode | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| lsb_first | input | 1 | 1 selects least-significant-first order |
| cs_sel | input | 2 | Index of the slave to select |
| clk_div | input | 8 | SCLK half-period minus one, in system clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rx_word | output | 32 | Received word |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 4 | Active-low chip selects |
| sd_out | output | 4 | Serial data out, per lane |
| sd_oe | output | 4 | Output enable, per lane |
| sd_in | input | 4 | Serial data in, per lane |

## Verification
The hardest case to reach from the ports is a request that arrives mid-transfer with every setup input changed. It must leave the chip select, the lane enables, the shifted bits and the cycle count untouched. The bench reaches it in about half of all transfers by pulsing `start` on the fourth clock of the transfer, while also changing the slave index, lane code, length, order and divider. It then checks that the result matches the original setup and that no second transfer follows. A bench slave model drives random values on the unused input lanes, so any leak of those lanes into the received word shows up. It sweeps every lane code, length and order at three divider settings.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_DONE  = 2'd2
   } eng_state_e;

   // log2 of the number of active lanes; codes 2 and 3 both mean four lanes
   function automatic logic [1:0] lane_log2(input logic [1:0] code);
      case (code)
         2'd0:    lane_log2 = 2'd0;
         2'd1:    lane_log2 = 2'd1;
         default: lane_log2 = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/mlspi_divider.sv
module mlspi_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mlspi_lane_io.sv
module mlspi_lane_io (
   input  logic       active,
   input  logic [1:0] lane_sh,
   input  logic       lsb_q,
   input  logic [3:0] hi4,
   input  logic [3:0] lo4,
   input  logic [3:0] sd_in,
   output logic [3:0] sd_out,
   output logic [3:0] sd_oe,
   output logic [3:0] din_m
);

   logic [2:0] lane_n;
   logic [3:0] lane_on;
   logic [3:0] grp;

   assign lane_n = 3'd1 << lane_sh;

   always_comb begin
      case (lane_sh)
         2'd0:    grp = {3'b000, lsb_q ? lo4[0]   : hi4[3]};
         2'd1:    grp = {2'b00,  lsb_q ? lo4[1:0] : hi4[3:2]};
         default: grp = lsb_q ? lo4 : hi4;
      endcase
   end

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assign lane_on[l] = (lane_n > 3'(l));
      assign sd_oe[l]   = active & lane_on[l];
      assign sd_out[l]  = active & lane_on[l] & grp[l];
      assign din_m[l]   = sd_in[l] & lane_on[l];
   end

endmodule

// File: rtl/mlspi_datapath.sv
module mlspi_datapath #(
   parameter int DATA_W = 32,
   localparam int LEN_W = $clog2(DATA_W / 4),
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              lsb_first,
   input  logic [LEN_W-1:0]  len_q,
   input  logic              lsb_q,
   input  logic [1:0]        lane_sh,
   input  logic              sample,
   input  logic              shift_out,
   input  logic              finish,
   input  logic [3:0]        din_m,
   output logic [3:0]        hi4,
   output logic [3:0]        lo4,
   output logic [DATA_W-1:0] rx_word
);

   logic [DATA_W-1:0] tx_sr, rx_sr, din_ext, len_mask;
   logic [CNT_W-1:0]  bits_ld, bits_q, pad_ld, pad_q, top_sh;
   logic [2:0]        lane_n;

   assign lane_n   = 3'd1 << lane_sh;
   assign bits_ld  = CNT_W'((32'(len_code) + 32'd1) * 32'd4);
   assign bits_q   = CNT_W'((32'(len_q) + 32'd1) * 32'd4);
   assign pad_ld   = CNT_W'(DATA_W) - bits_ld;
   assign pad_q    = CNT_W'(DATA_W) - bits_q;
   assign top_sh   = CNT_W'(DATA_W) - CNT_W'(lane_n);
   assign len_mask = {DATA_W{1'b1}} >> pad_ld;
   assign din_ext  = DATA_W'(din_m);
   assign hi4      = tx_sr[DATA_W-1 -: 4];
   assign lo4      = tx_sr[3:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         rx_word <= '0;
      end else if (load) begin
         tx_sr <= lsb_first ? (tx_word & len_mask) : (tx_word << pad_ld);
         rx_sr <= '0;
      end else begin
         if (shift_out) begin
            tx_sr <= lsb_q ? (tx_sr >> lane_n) : (tx_sr << lane_n);
         end
         if (sample) begin
            rx_sr <= lsb_q ? ((rx_sr >> lane_n) | (din_ext << top_sh))
                           : ((rx_sr << lane_n) | din_ext);
         end
         if (finish) begin
            rx_word <= lsb_q ? (rx_sr >> pad_q) : rx_sr;
         end
      end
   end

endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine
   import mlspi_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM_CS = 4,
   parameter int DIV_W  = 8,
   localparam int LEN_W = $clog2(DATA_W / 4),
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_word,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [1:0]        lane_mode,
   input  logic              lsb_first,
   input  logic [CS_W-1:0]   cs_sel,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs_n,
   output logic [3:0]        sd_out,
   output logic [3:0]        sd_oe,
   input  logic [3:0]        sd_in
);

   if (DATA_W % 4 != 0 || (4 << LEN_W) != DATA_W) begin : g_bad_width
      $error("mlspi_engine: DATA_W must be 4 times a power of two");
   end
   if (NUM_CS < 1) begin : g_bad_cs
      $error("mlspi_engine: NUM_CS must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("mlspi_engine: DIV_W must be at least 1");
   end

   eng_state_e        state_q;
   logic              sclk_q, lsb_q, tick, active, accept;
   logic              sample, fall, shift_out, finish;
   logic [1:0]        lane_q;
   logic [LEN_W-1:0]  len_q;
   logic [CS_W-1:0]   cs_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W-1:0]  cyc_left, cyc_init, bits_in;
   logic [3:0]        hi4, lo4, din_m;

   assign active    = (state_q == ST_SHIFT);
   assign accept    = (state_q == ST_IDLE) && start;
   assign sample    = active && tick && !sclk_q;
   assign fall      = active && tick && sclk_q;
   assign shift_out = fall && (cyc_left != CNT_W'(1));
   assign finish    = fall && (cyc_left == CNT_W'(1));
   assign bits_in   = CNT_W'((32'(len_code) + 32'd1) * 32'd4);
   assign cyc_init  = bits_in >> lane_log2(lane_mode);

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_DONE);
   assign sclk = sclk_q;

   for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
      assign cs_n[c] = !(active && (cs_q == CS_W'(c)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sclk_q   <= 1'b0;
         lane_q   <= '0;
         len_q    <= '0;
         lsb_q    <= 1'b0;
         cs_q     <= '0;
         div_q    <= '0;
         cyc_left <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               sclk_q <= 1'b0;
               if (start) begin
                  state_q  <= ST_SHIFT;
                  lane_q   <= lane_mode;
                  len_q    <= len_code;
                  lsb_q    <= lsb_first;
                  cs_q     <= cs_sel;
                  div_q    <= clk_div;
                  cyc_left <= cyc_init;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sclk_q <= !sclk_q;
                  if (sclk_q) begin
                     if (cyc_left == CNT_W'(1)) begin
                        state_q <= ST_DONE;
                     end
                     cyc_left <= cyc_left - 1'b1;
                  end
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   mlspi_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active),
      .div   (div_q),
      .tick  (tick)
   );

   mlspi_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .tx_word   (tx_word),
      .len_code  (len_code),
      .lsb_first (lsb_first),
      .len_q     (len_q),
      .lsb_q     (lsb_q),
      .lane_sh   (lane_log2(lane_q)),
      .sample    (sample),
      .shift_out (shift_out),
      .finish    (finish),
      .din_m     (din_m),
      .hi4       (hi4),
      .lo4       (lo4),
      .rx_word   (rx_word)
   );

   mlspi_lane_io u_io (
      .active  (active),
      .lane_sh (lane_log2(lane_q)),
      .lsb_q   (lsb_q),
      .hi4     (hi4),
      .lo4     (lo4),
      .sd_in   (sd_in),
      .sd_out  (sd_out),
      .sd_oe   (sd_oe),
      .din_m   (din_m)
   );

endmodule

// File: rtl/mlspi_engine_chk.sv
module mlspi_engine_chk #(
   parameter int DATA_W = 32,
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              sclk,
   input logic [NUM_CS-1:0] cs_n,
   input logic [3:0]        sd_oe,
   input logic [DATA_W-1:0] rx_word
);

   // R6
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R5
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk);

   // R5
   sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !$past(&cs_n));

   // R8
   done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (&cs_n));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word) |-> done);

   // R3
   oe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_oe == 4'b0000) || (sd_oe == 4'b0001) || (sd_oe == 4'b0011) || (sd_oe == 4'b1111));

   // R3
   oe_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> (sd_oe == 4'b0000));

endmodule

bind mlspi_engine mlspi_engine_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/sim_mlspi_engine.sv
`timescale 1ns/1ps
module sim_mlspi_engine;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [31:0] tx_word;
   logic [2:0]  len_code;
   logic [1:0]  lane_mode;
   logic        lsb_first;
   logic [1:0]  cs_sel;
   logic [7:0]  clk_div;
   logic        busy, done, sclk;
   logic [31:0] rx_word;
   logic [3:0]  cs_n, sd_out, sd_oe, sd_in;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mlspi_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .len_code(len_code), .lane_mode(lane_mode), .lsb_first(lsb_first),
      .cs_sel(cs_sel), .clk_div(clk_div), .busy(busy), .done(done),
      .rx_word(rx_word), .sclk(sclk), .cs_n(cs_n), .sd_out(sd_out),
      .sd_oe(sd_oe), .sd_in(sd_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] grp_of(input logic [31:0] word, input int len,
                                         input int w, input bit lsb, input int k);
      logic [31:0] s;
      s = lsb ? (word >> (k * w)) : (word >> (len - (k + 1) * w));
      return 4'(s) & 4'((1 << w) - 1);
   endfunction

   task automatic run_xfer(input int code, input int lc, input bit lsb,
                           input int sel, input int dv, input bit poke);
      int w, len, n, k, low_cnt, cyc, bad_cs, bad_oe;
      logic [31:0] txw, slv, wmask, cap;
      logic [3:0]  lmask, exp_oe;
      bit prev;
      w      = (code == 0) ? 1 : (code == 1) ? 2 : 4;
      len    = 4 * (lc + 1);
      n      = len / w;
      lmask  = 4'((1 << w) - 1);
      exp_oe = lmask;
      wmask  = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
      txw    = $urandom;
      slv    = $urandom;
      k = 0; low_cnt = 0; cyc = 0; bad_cs = 0; bad_oe = 0; cap = 0; prev = 1'b0;

      @(negedge clk);
      tx_word = txw; len_code = 3'(lc); lane_mode = 2'(code); lsb_first = lsb;
      cs_sel = 2'(sel); clk_div = 8'(dv); start = 1'b1;
      sd_in = grp_of(slv, len, w, lsb, 0) | (4'($urandom) & ~lmask);
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 5000) begin
         if (cs_n[sel] == 1'b0) begin
            low_cnt++;
            if (cs_n != ~(4'b0001 << sel)) bad_cs++;
            if (sd_oe != exp_oe) bad_oe++;
            if (sclk && !prev) begin
               cap = lsb ? (cap | (32'(sd_out & lmask) << (k * w)))
                         : ((cap << w) | 32'(sd_out & lmask));
               k++;
               if (k < n) sd_in = grp_of(slv, len, w, lsb, k) | (4'($urandom) & ~lmask);
            end
         end
         prev = sclk;
         if (poke && cyc == 3) begin
            // R7: new request with every setup field changed while busy
            start = 1'b1; tx_word = ~txw; cs_sel = 2'(sel + 1);
            lane_mode = 2'((code + 1) % 3); len_code = 3'(lc) ^ 3'h5;
            lsb_first = ~lsb; clk_div = 8'(dv + 2);
         end
         if (poke && cyc == 4) start = 1'b0;
         cyc++;
         @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1, "R8", "done seen", 32'(done), 32'd1);
      chk(cs_n == 4'hF, "R8", "cs released at done", 32'(cs_n), 32'hF);
      chk(rx_word == (slv & wmask), "R4", "received word", rx_word, slv & wmask);
      chk(cap == (txw & wmask), "R2", "transmitted groups", cap, txw & wmask);
      chk(k == n, "R1", "sclk cycle count", 32'(k), 32'(n));
      chk(low_cnt == 2 * n * (dv + 1), "R5", "select low clocks", 32'(low_cnt),
          32'(2 * n * (dv + 1)));
      chk(bad_cs == 0, "R6", "only selected cs low", 32'(bad_cs), 32'd0);
      chk(bad_oe == 0, "R3", "lane enables", 32'(bad_oe), 32'd0);
      @(negedge clk);
      chk(done == 1'b0, "R8", "done one clock", 32'(done), 32'd0);
      chk(rx_word == (slv & wmask), "R8", "rx held", rx_word, slv & wmask);
      chk(busy == 1'b0 && cs_n == 4'hF, "R7", "no second transfer",
          {27'd0, busy, cs_n}, 32'h0000000F);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; tx_word = '0; len_code = '0; lane_mode = '0;
      lsb_first = 1'b0; cs_sel = '0; clk_div = '0; sd_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      chk(cs_n == 4'hF, "R9", "reset cs_n", 32'(cs_n), 32'hF);
      chk(sclk == 1'b0, "R9", "reset sclk", 32'(sclk), 32'd0);
      chk(sd_oe == 4'h0, "R9", "reset sd_oe", 32'(sd_oe), 32'd0);
      chk(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done",
          {30'd0, busy, done}, 32'd0);
      chk(rx_word == 32'd0, "R9", "reset rx_word", rx_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      foreach (clk_div[i]) begin end
      for (int d = 0; d < 3; d++) begin
         for (int code = 0; code < 3; code++) begin
            for (int lc = 0; lc < 8; lc++) begin
               for (int lsb = 0; lsb < 2; lsb++) begin
                  run_xfer(code, lc, lsb[0], (lc + code + d) % 4,
                           (d == 2) ? 3 : d, lc[0] ^ lsb[0]);
               end
            end
         end
      end
      // R3: lane code 3 behaves as quad
      for (int lc = 0; lc < 8; lc += 3) begin
         run_xfer(3, lc, lc[0], lc % 4, 1, 1'b1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule